// File: doc/BRIEF.md
# Microwire Serial EEPROM Responder

This block is a synchronous model of a three-wire serial EEPROM slave that holds 64 words of 16 bits. A fast system clock samples the chip-select, serial-clock and serial-data pins. Each rising edge of the serial clock is detected after synchronisation. While the block receives, each such edge shifts one command bit in. The block knows seven commands, each framed by a leading start bit: read, write, erase, write-all, erase-all, write-enable and write-disable. A command takes effect on the serial-clock edge that completes its bit pattern. Nothing waits for the end of the chip-select window.

The data-out pin has two uses. After a read is decoded it streams the stored words, most significant bit first. The address then steps on by one, wrapping from the last word to the first, for as long as the host keeps clocking. In every other case the pin reports ready or busy. A short countdown, measured in system-clock cycles, shows busy after chip-select falls. Writes are blocked until write-enable is decoded, and reset leaves the block locked.

The pins are plain levels and carry no valid/ready handshake. The host paces every transfer through the serial clock and the block cannot apply back-pressure. The host must therefore hold each serial-clock level, and the data-in level around each rise, for at least three system-clock cycles.

Top module: `mwire_eeprom`

## Requirements
- R1: After reset, do_o is 1 (ready) and every stored word reads 0xFFFF.
- R2: While chip-select is low, any partly received command is discarded and a read stream in progress ends. The next command sent with chip-select high is decoded from its own start bit.
- R3: The bit pattern 1,1,0 followed by a 6-bit address (MSB first) decodes as a read. On the first serial-clock rise after the last address bit, do_o shows bit 15 of the addressed word. Each later rise shows the next lower bit.
- R4: A read continues without a gap bit after 16 bits. It moves on to the next address, and address 63 is followed by address 0.
- R5: The five bits 1,0,0,1,1 unlock writes and the five bits 1,0,0,0,0 lock them. Reset leaves writes locked.
- R6: The 25-bit frame 1,0,1, then a 6-bit address, then 16 data bits (all MSB first), stores the data word at that address. This happens only while writes are unlocked.
- R7: The 25-bit frame 1,0,0,0,1, then four don't-care bits, then 16 data bits, stores the data word in all 64 locations. This happens only while writes are unlocked.
- R8: The frame 1,1,1 plus a 6-bit address sets that word to 0xFFFF. The 9-bit frame 1,0,0,1,0 plus four don't-care bits sets every word to 0xFFFF. Both have no effect while writes are locked.
- R9: Write, write-all, erase and erase-all each drive do_o to 1 on the serial-clock rise that completes them. This happens even when the lock blocks the store and even when a busy count is pending.
- R10: A busy countdown starts when chip-select falls. Three clock cycles after the fall, do_o reads 0 for exactly 5 consecutive system-clock cycles and then reads 1. The count runs only while chip-select is low and is held while chip-select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial command and data input |
| do_o | output | 1 | Read data in a read stream, otherwise ready (1) or busy (0) |

## Verification
The main function is exercised with a fixed sequence of commands, and every read takes two words so that the address step is always checked. Asymmetric data words such as 0xA5C3 and 0xBEEF show a reversed bit order. A read starting at address 63 separates a correct wrap from a stall or an overrun. Each write-class command is sent once while locked and once while unlocked, and the result is read back; this tells a command that was really ignored from one that was decoded wrongly. Directed sequences check three more things:
- a partial frame followed by a chip-select drop;
- the busy count held by an early chip-select rise and then cleared by an erase;
- an exact count of busy cycles after chip-select falls.

// File: rtl/mwire_pkg.sv
package mwire_pkg;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_READ,
    CMD_WRITE,
    CMD_ERASE,
    CMD_FILL,
    CMD_WIPE,
    CMD_UNLOCK,
    CMD_LOCK
  } mw_cmd_e;

endpackage

// File: rtl/mwire_sync.sv
module mwire_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_s,
  output logic sk_rise,
  output logic di_s
);
  logic [2:0] stage1_q, stage2_q;
  logic       sk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q  <= '0;
      stage2_q  <= '0;
      sk_prev_q <= 1'b0;
    end else begin
      stage1_q  <= {cs_i, sk_i, di_i};
      stage2_q  <= stage1_q;
      sk_prev_q <= stage2_q[1];
    end
  end

  assign cs_s    = stage2_q[2];
  assign di_s    = stage2_q[0];
  assign sk_rise = stage2_q[1] & ~sk_prev_q;
endmodule

// File: rtl/mwire_decode.sv
module mwire_decode import mwire_pkg::*; #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int SHIFT_W = 32
) (
  input  logic [SHIFT_W-2:0] shift_q,
  input  logic               di,
  output mw_cmd_e            cmd,
  output logic [ADDR_W-1:0]  addr,
  output logic [DATA_W-1:0]  data,
  output logic               wr_class
);
  logic [SHIFT_W-1:0] frame;
  assign frame = {shift_q, di};

  always_comb begin
    cmd = CMD_NONE;
    if (frame == SHIFT_W'(5'b10011))                            cmd = CMD_UNLOCK;
    else if (frame == SHIFT_W'(5'b10000))                       cmd = CMD_LOCK;
    else if ((frame >> ADDR_W) == SHIFT_W'(3'b110))             cmd = CMD_READ;
    else if ((frame >> ADDR_W) == SHIFT_W'(3'b111))             cmd = CMD_ERASE;
    else if ((frame >> (ADDR_W - 2)) == SHIFT_W'(5'b10010))     cmd = CMD_WIPE;
    else if ((frame >> (ADDR_W + DATA_W)) == SHIFT_W'(3'b101))  cmd = CMD_WRITE;
    else if ((frame >> (ADDR_W - 2 + DATA_W)) == SHIFT_W'(5'b10001)) cmd = CMD_FILL;
  end

  assign addr     = (cmd == CMD_WRITE) ? frame[DATA_W +: ADDR_W] : frame[ADDR_W-1:0];
  assign data     = frame[DATA_W-1:0];
  assign wr_class = (cmd == CMD_WRITE) || (cmd == CMD_ERASE) ||
                    (cmd == CMD_FILL)  || (cmd == CMD_WIPE);
endmodule

// File: rtl/mwire_store.sv
module mwire_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_one,
  input  logic              we_all,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we_all || (we_one && (wr_addr == ADDR_W'(i)))) mem_q[i] <= wdata;
      end
    end
  end

  assign rdata = mem_q[rd_addr];
endmodule

// File: rtl/mwire_eeprom.sv
module mwire_eeprom import mwire_pkg::*; #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o
);
  localparam int SHIFT_W = (ADDR_W + DATA_W + 3 > 32) ? (ADDR_W + DATA_W + 3) : 32;
  localparam int BUSY_W  = $clog2(BUSY_CYCLES + 1);
  localparam int CNT_W   = $clog2(DATA_W);

  logic cs_s, sk_rise, di_s;

  mwire_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_i    (cs_i),
    .sk_i    (sk_i),
    .di_i    (di_i),
    .cs_s    (cs_s),
    .sk_rise (sk_rise),
    .di_s    (di_s)
  );

  logic [SHIFT_W-2:0] shift_q;
  logic               rx_q, locked_q, cs_prev_q, out_bit_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  out_sh_q;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic [BUSY_W-1:0]  busy_q;

  mw_cmd_e           dec_cmd;
  logic [ADDR_W-1:0] dec_addr;
  logic [DATA_W-1:0] dec_data;
  logic              dec_wr_class;

  mwire_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_decode (
    .shift_q  (shift_q),
    .di       (di_s),
    .cmd      (dec_cmd),
    .addr     (dec_addr),
    .data     (dec_data),
    .wr_class (dec_wr_class)
  );

  logic              rx_step, wr_evt, we_one, we_all, wipe_val;
  logic [DATA_W-1:0] st_wdata, st_rdata;
  logic [ADDR_W-1:0] st_rd_addr;

  assign rx_step    = cs_s & sk_rise & rx_q;
  assign wr_evt     = rx_step & dec_wr_class;
  assign wipe_val   = (dec_cmd == CMD_ERASE) || (dec_cmd == CMD_WIPE);
  assign we_one     = rx_step & ~locked_q & ((dec_cmd == CMD_WRITE) || (dec_cmd == CMD_ERASE));
  assign we_all     = rx_step & ~locked_q & ((dec_cmd == CMD_FILL) || (dec_cmd == CMD_WIPE));
  assign st_wdata   = wipe_val ? '1 : dec_data;
  assign st_rd_addr = rx_q ? dec_addr : addr_q + 1'b1;

  mwire_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_one  (we_one),
    .we_all  (we_all),
    .wr_addr (dec_addr),
    .wdata   (st_wdata),
    .rd_addr (st_rd_addr),
    .rdata   (st_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q   <= '0;
      rx_q      <= 1'b1;
      locked_q  <= 1'b1;
      cs_prev_q <= 1'b0;
      out_bit_q <= 1'b0;
      addr_q    <= '0;
      out_sh_q  <= '0;
      bit_cnt_q <= '0;
      busy_q    <= '0;
    end else begin
      cs_prev_q <= cs_s;
      if (!cs_s) begin
        shift_q <= '0;
        rx_q    <= 1'b1;
        if (cs_prev_q)          busy_q <= BUSY_W'(BUSY_CYCLES);
        else if (busy_q != '0)  busy_q <= busy_q - 1'b1;
      end else if (sk_rise) begin
        if (rx_q) begin
          shift_q <= {shift_q[SHIFT_W-3:0], di_s};
          if (wr_evt) busy_q <= '0;
          case (dec_cmd)
            CMD_READ: begin
              rx_q      <= 1'b0;
              addr_q    <= dec_addr;
              out_sh_q  <= st_rdata;
              bit_cnt_q <= '0;
              out_bit_q <= 1'b0;
            end
            CMD_UNLOCK: locked_q <= 1'b0;
            CMD_LOCK:   locked_q <= 1'b1;
            default: ;
          endcase
        end else begin
          out_bit_q <= out_sh_q[DATA_W-1];
          if (bit_cnt_q == CNT_W'(DATA_W - 1)) begin
            addr_q    <= addr_q + 1'b1;
            out_sh_q  <= st_rdata;
            bit_cnt_q <= '0;
          end else begin
            out_sh_q  <= out_sh_q << 1;
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign do_o = rx_q ? (busy_q == '0) : out_bit_q;
endmodule

// File: rtl/mwire_eeprom_chk.sv
module mwire_eeprom_chk #(
  parameter int BUSY_CYCLES = 5,
  parameter int BUSY_W      = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              rx,
  input logic              locked,
  input logic [BUSY_W-1:0] busy,
  input logic              do_o,
  input logic              wr_evt,
  input logic              we_one,
  input logic              we_all
);
  p_busy_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy <= BUSY_W'(BUSY_CYCLES));

  p_busy_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_s) |=> !do_o);

  p_busy_steps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !$past(cs_s) && busy != '0) |=> busy == $past(busy) - 1'b1);

  p_ready_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> do_o);

  p_receive_on_cs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> rx);

  p_store_needs_unlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_one || we_all) |-> !locked);
endmodule

bind mwire_eeprom mwire_eeprom_chk #(.BUSY_CYCLES(BUSY_CYCLES), .BUSY_W(BUSY_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_s   (cs_s),
  .rx     (rx_q),
  .locked (locked_q),
  .busy   (busy_q),
  .do_o   (do_o),
  .wr_evt (wr_evt),
  .we_one (we_one),
  .we_all (we_all)
);

// File: tb/mwire_eeprom_test.sv
`timescale 1ns/1ps
module mwire_eeprom_test;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_w;
  always #4 clk = ~clk;

  mwire_eeprom uut (.clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .do_o(do_w));

  int checks = 0, errors = 0;
  logic [15:0] model [64];
  logic unlocked = 1'b0;

  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_ER = 3'd2, OP_WA = 3'd3,
                         OP_EA = 3'd4, OP_EN = 3'd5, OP_DS = 3'd6;
  typedef struct packed { logic [2:0] op; logic [5:0] a; logic [15:0] d; } vec_t;
  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{OP_RD, 6'd0,  16'h0000},  // R1 fresh contents
    '{OP_WR, 6'd5,  16'h1234},  // R6 locked, ignored
    '{OP_RD, 6'd5,  16'h0000},
    '{OP_EN, 6'd0,  16'h0000},  // R5 unlock
    '{OP_WR, 6'd5,  16'hA5C3},  // R6
    '{OP_WR, 6'd6,  16'h0F0F},
    '{OP_RD, 6'd5,  16'h0000},  // R3 order, R4 step
    '{OP_ER, 6'd5,  16'h0000},  // R8 single erase
    '{OP_RD, 6'd4,  16'h0000},
    '{OP_WR, 6'd63, 16'hBEEF},
    '{OP_WR, 6'd0,  16'h1357},
    '{OP_RD, 6'd63, 16'h0000},  // R4 wrap
    '{OP_DS, 6'd0,  16'h0000},  // R5 lock
    '{OP_EA, 6'd0,  16'h0000},  // R8 locked, ignored
    '{OP_RD, 6'd63, 16'h0000},
    '{OP_EN, 6'd0,  16'h0000},
    '{OP_WA, 6'd0,  16'h6A6A},  // R7 fill
    '{OP_RD, 6'd10, 16'h0000},
    '{OP_EA, 6'd0,  16'h0000},  // R8 erase all
    '{OP_RD, 6'd20, 16'h0000},
    '{OP_DS, 6'd0,  16'h0000},
    '{OP_WA, 6'd0,  16'h1111},  // R7 locked, ignored
    '{OP_RD, 6'd20, 16'h0000},
    '{OP_EN, 6'd0,  16'h0000},
    '{OP_WR, 6'd9,  16'hC001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bit_out(input logic b, output logic s);
    di = b; sk = 1'b0; cyc(4);
    sk = 1'b1; cyc(5);
    s = do_w;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic s;
    for (int i = n - 1; i >= 0; i--) bit_out(v[i], s);
  endtask

  task automatic start_cmd();
    cs = 1'b1; sk = 1'b0; cyc(4);
  endtask

  task automatic end_cmd();
    sk = 1'b0; cyc(2); cs = 1'b0; cyc(12);
  endtask

  task automatic read_words(input logic [5:0] a, input int nw, input string tag0);
    logic s;
    logic [15:0] word;
    logic [5:0] wa;
    start_cmd();
    send({23'd0, 3'b110, a}, 9);
    for (int w = 0; w < nw; w++) begin
      word = '0;
      for (int b = 0; b < 16; b++) begin
        bit_out(1'b0, s);
        word = {word[14:0], s};
      end
      wa = a + 6'(w);
      chk((w == 0) ? tag0 : "R4 next word", {16'd0, word}, {16'd0, model[wa]});
    end
    end_cmd();
  endtask

  task automatic wr_done(input string tag);
    chk(tag, {31'd0, do_w}, 32'd1);
    end_cmd();
  endtask

  task automatic apply(input vec_t v);
    case (v.op)
      OP_RD: read_words(v.a, 2, "R3 first word");
      OP_WR: begin
        start_cmd(); send({7'd0, 3'b101, v.a, v.d}, 25); wr_done("R9 after write");
        if (unlocked) model[v.a] = v.d;
      end
      OP_ER: begin
        start_cmd(); send({23'd0, 3'b111, v.a}, 9); wr_done("R9 after erase");
        if (unlocked) model[v.a] = 16'hFFFF;
      end
      OP_WA: begin
        start_cmd(); send({7'd0, 5'b10001, 4'd0, v.d}, 25); wr_done("R9 after fill");
        if (unlocked) for (int i = 0; i < 64; i++) model[i] = v.d;
      end
      OP_EA: begin
        start_cmd(); send({23'd0, 5'b10010, 4'd0}, 9); wr_done("R9 after wipe");
        if (unlocked) for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
      end
      OP_EN: begin start_cmd(); send(32'b10011, 5); end_cmd(); unlocked = 1'b1; end
      OP_DS: begin start_cmd(); send(32'b10000, 5); end_cmd(); unlocked = 1'b0; end
      default: ;
    endcase
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic s;
    int zeros;
    logic [8:0] ev;
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    cyc(3); rst_n = 1'b1; cyc(3);
    chk("R1 ready after reset", {31'd0, do_w}, 32'd1);

    for (int k = 0; k < NV; k++) apply(TBL[k]);

    // R2: partial read frame abandoned by chip-select low
    start_cmd(); send({26'd0, 3'b110, 3'b001}, 6); end_cmd();
    read_words(6'd9, 1, "R2 after partial frame");
    // R2: read stream cut short mid-word
    start_cmd(); send({23'd0, 3'b110, 6'd63}, 9);
    for (int b = 0; b < 5; b++) bit_out(1'b0, s);
    end_cmd();
    read_words(6'd0, 1, "R2 after aborted stream");

    // R10 hold while chip-select is high, then R9 clears pending busy
    cs = 1'b1; cyc(4); cs = 1'b0; cyc(4); cs = 1'b1; cyc(4);
    chk("R10 count held while selected", {31'd0, do_w}, 32'd0);
    ev = {3'b111, 6'd9};
    send({24'd0, ev[8:1]}, 8);
    chk("R9 busy before erase completes", {31'd0, do_w}, 32'd0);
    send({31'd0, ev[0]}, 1);
    chk("R9 ready on erase completion", {31'd0, do_w}, 32'd1);
    model[9] = 16'hFFFF;
    sk = 1'b0; cyc(2);
    cs = 1'b0; zeros = 0;
    for (int c = 0; c < 14; c++) begin
      cyc(1);
      if (!do_w) zeros++;
    end
    chk("R10 busy length", 32'(zeros), 32'd5);
    chk("R10 ready after count", {31'd0, do_w}, 32'd1);
    read_words(6'd9, 1, "R8 erased word");

    // R1/R5: second reset restores contents and lock
    start_cmd(); send({7'd0, 3'b101, 6'd12, 16'h5555}, 25); end_cmd();
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(2);
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    unlocked = 1'b0;
    chk("R1 ready after second reset", {31'd0, do_w}, 32'd1);
    read_words(6'd12, 1, "R1 contents after reset");
    start_cmd(); send({7'd0, 3'b101, 6'd12, 16'hABCD}, 25); end_cmd();
    read_words(6'd12, 1, "R5 locked after reset");

    summary();
    $finish;
  end
endmodule